// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a compare-and-trap instruction fires. It takes two register operands and a five-bit condition mask. It works out five relations between the operands at once: signed less, signed greater, equal, unsigned less and unsigned greater. It requests a program trap when at least one relation selected by the mask is true.

A mode input sets the compare width. In word mode only the low 32 bits of each operand take part. In doubleword mode all 64 bits take part. The decision is registered, so a request appears one clock after a valid operation is presented. The request carries a fixed trap reason code, which the exception logic downstream uses to tell a conditional trap from other program faults. Vectoring and saving the return address belong to that downstream logic.

Top module: `trap_cond_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B as signed numbers.
- R2: Mask bit 3 (value 0x08) enables a trap when A is greater than B as signed numbers.
- R3: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R4: Mask bit 1 (value 0x02) enables a trap on unsigned A < B, and mask bit 0 (value 0x01) enables a trap on unsigned A > B.
- R5: When `dword_mode` is 0 (word mode), only bits 31:0 of each operand are compared, and bits 63:32 have no effect on the result.
- R6: When `dword_mode` is 1, all 64 bits of each operand are compared.
- R7: A trap is requested when any one of the enabled relations holds. It does not matter which one holds or how many hold.
- R8: A mask of 0 never requests a trap. A mask of 5'b11111 always requests a trap for a valid operation.
- R9: `trap_req` is high exactly in the cycle after a cycle in which `in_valid` was high and a trap condition held. It is low after a cycle with `in_valid` low and is low out of reset.
- R10: `trap_code` equals the parameter `TRAP_REASON` (default 4'h2) while `trap_req` is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation valid strobe |
| op_a | input | 64 | First operand (A) |
| op_b | input | 64 | Second operand (B) |
| cond_mask | input | 5 | Trap condition enables: bits 4 to 0 are signed less, signed greater, equal, unsigned less, unsigned greater |
| dword_mode | input | 1 | 0: compare the low 32 bits; 1: compare all 64 bits |
| trap_req | output | 1 | Registered trap request |
| trap_code | output | 4 | Trap reason code while a request is raised, else 0 |

## Verification
Operand pairs are chosen so that the signed and unsigned orderings disagree, for example a value with the sign bit set against a small positive one. These pairs show whether each mask bit is wired to the right relation and whether the signed and unsigned relations are swapped. Some pairs differ only in bits 63:32. Run in both modes, they show whether word mode ignores the upper half and whether doubleword mode uses it. Applying the all-zero mask, the all-one mask and single-bit masks to equal and unequal pairs, with the strobe both high and low, checks the OR of the relations and the one-cycle registered timing.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
   // number of relations evaluated in parallel, and their bit positions in the mask
   localparam int unsigned REL_N   = 5;
   localparam int unsigned REL_UGT = 0;
   localparam int unsigned REL_ULT = 1;
   localparam int unsigned REL_EQ  = 2;
   localparam int unsigned REL_SGT = 3;
   localparam int unsigned REL_SLT = 4;

   typedef logic [REL_N-1:0] rel_vec_t;
endpackage

// File: rtl/trap_rel_eval.sv
// Evaluates all five operand relations for one compare width.
module trap_rel_eval
   import trap_cmp_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output rel_vec_t     rel
);
   initial begin
      assert (W >= 2) else $error("trap_rel_eval: W must be at least 2");
   end

   logic s_lt, s_gt, u_lt, u_gt, eq;

   always_comb begin
      s_lt = $signed(a) < $signed(b);
      s_gt = $signed(a) > $signed(b);
      u_lt = a < b;
      u_gt = a > b;
      eq   = a == b;
   end

   always_comb begin
      rel          = '0;
      rel[REL_SLT] = s_lt;
      rel[REL_SGT] = s_gt;
      rel[REL_EQ]  = eq;
      rel[REL_ULT] = u_lt;
      rel[REL_UGT] = u_gt;
   end
endmodule

// File: rtl/trap_mask_reduce.sv
// Gates the relation vector with the condition mask and ORs the survivors.
module trap_mask_reduce
   import trap_cmp_pkg::*;
(
   input  rel_vec_t rel,
   input  rel_vec_t mask,
   output logic     hit
);
   rel_vec_t gated;

   always_comb begin
      gated = rel & mask;
      hit   = |gated;
   end
endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
   import trap_cmp_pkg::*;
#(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned CODE_W      = 4,
   parameter logic [CODE_W-1:0] TRAP_REASON = 4'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [REL_N-1:0]  cond_mask,
   input  logic              dword_mode,
   output logic              trap_req,
   output logic [CODE_W-1:0] trap_code
);
   localparam bit HAS_NARROW = (WORD_W < DATA_W);

   initial begin
      assert (WORD_W >= 2 && WORD_W <= DATA_W)
         else $error("trap_cond_unit: WORD_W must lie in 2..DATA_W");
      assert (TRAP_REASON != '0)
         else $error("trap_cond_unit: TRAP_REASON must be nonzero");
   end

   rel_vec_t rel_full;
   rel_vec_t rel_word;
   rel_vec_t rel_sel;
   logic     hit;

   trap_rel_eval #(.W(DATA_W)) u_full (
      .a   (op_a),
      .b   (op_b),
      .rel (rel_full)
   );

   generate
      if (HAS_NARROW) begin : g_narrow
         trap_rel_eval #(.W(WORD_W)) u_word (
            .a   (op_a[WORD_W-1:0]),
            .b   (op_b[WORD_W-1:0]),
            .rel (rel_word)
         );
      end else begin : g_same
         // word and full width coincide: one evaluator serves both modes
         assign rel_word = rel_full;
      end
   endgenerate

   always_comb rel_sel = dword_mode ? rel_full : rel_word;

   trap_mask_reduce u_reduce (
      .rel  (rel_sel),
      .mask (cond_mask),
      .hit  (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_req  <= 1'b0;
         trap_code <= '0;
      end else begin
         trap_req  <= in_valid & hit;
         trap_code <= (in_valid & hit) ? TRAP_REASON : '0;
      end
   end

   // R9: a request only follows a valid operation
   p_req_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(in_valid));

   // R8: an all-zero mask never requests a trap
   p_zero_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && ($past(cond_mask) == '0)) |-> !trap_req);

   // R8: an all-one mask always requests a trap
   p_full_mask_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(cond_mask) == '1)) |-> trap_req);

   // R3: equal operands with the equal enable set must trap in either mode
   p_equal_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && $past(cond_mask[REL_EQ])
       && ($past(op_a) == $past(op_b))) |-> trap_req);

   // R10: reason code present exactly with a request
   p_code_with_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (trap_code == TRAP_REASON));
   p_code_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> (trap_code == '0));
endmodule

// File: tb/trap_cond_unit_tb.sv
module trap_cond_unit_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [3:0] REASON = 4'h2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [63:0] op_a, op_b;
   logic [4:0]  cond_mask;
   logic        dword_mode;
   logic        trap_req;
   logic [3:0]  trap_code;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trap_cond_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .op_a       (op_a),
      .op_b       (op_b),
      .cond_mask  (cond_mask),
      .dword_mode (dword_mode),
      .trap_req   (trap_req),
      .trap_code  (trap_code)
   );

   // expected trap decision, from the requirement text
   function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                                input logic [4:0] m, input logic dw);
      logic [63:0] ua, ub;
      logic signed [63:0] sa, sb;
      if (dw) begin
         ua = a; ub = b;
      end else begin
         ua = {32'h0, a[31:0]};
         ub = {32'h0, b[31:0]};
      end
      sa = dw ? $signed(a) : $signed({{32{a[31]}}, a[31:0]});
      sb = dw ? $signed(b) : $signed({{32{b[31]}}, b[31:0]});
      return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
             (m[1] && ua < ub) || (m[0] && ua > ub);
   endfunction

   task automatic check(input string req, input logic exp_req);
      logic [3:0] exp_code;
      exp_code = exp_req ? REASON : 4'h0;
      n_vec++;
      if (trap_req !== exp_req || trap_code !== exp_code) begin
         n_bad++;
         $display("FAIL %s: trap_req=%0b code=%0h, expected trap_req=%0b code=%0h",
                  req, trap_req, trap_code, exp_req, exp_code);
      end
   endtask

   // drive on a falling edge, the result is registered on the next rising edge
   // and read on the falling edge after it
   task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic [4:0] m, input logic dw, input logic v,
                        input logic exp_req);
      @(negedge clk);
      op_a = a; op_b = b; cond_mask = m; dword_mode = dw; in_valid = v;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, exp_req);
   endtask

   task automatic apply_model(input string req, input logic [63:0] a, input logic [63:0] b,
                              input logic [4:0] m, input logic dw);
      apply(req, a, b, m, dw, 1'b1, model(a, b, m, dw));
   endtask

   task automatic t_reset;
      rst_n = 1'b0; in_valid = 1'b1; op_a = '0; op_b = '0;
      cond_mask = 5'h1f; dword_mode = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 reset", 1'b0);
      in_valid = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_single_relations;
      // A has the sign bit set (32-bit): signed less, unsigned greater
      logic [63:0] neg32 = 64'h0000_0000_8000_0000;
      logic [63:0] one   = 64'h1;
      apply("R1 slt", neg32, one, 5'h10, 1'b0, 1'b1, 1'b1);
      apply("R2 sgt", neg32, one, 5'h08, 1'b0, 1'b1, 1'b0);
      apply("R4 ult", neg32, one, 5'h02, 1'b0, 1'b1, 1'b0);
      apply("R4 ugt", neg32, one, 5'h01, 1'b0, 1'b1, 1'b1);
      apply("R3 eq",  one, one, 5'h04, 1'b0, 1'b1, 1'b1);
      apply("R3 neq", neg32, one, 5'h04, 1'b0, 1'b1, 1'b0);
      apply("R2 sgt swap", one, neg32, 5'h08, 1'b0, 1'b1, 1'b1);
      apply("R4 ult swap", one, neg32, 5'h02, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_word_mode;
      // differ only in the upper half: equal in word mode
      apply("R5 upper ignored eq", 64'hFFFF_FFFF_0000_0001, 64'h1, 5'h04, 1'b0, 1'b1, 1'b1);
      apply("R5 upper ignored ugt", 64'hFFFF_FFFF_0000_0001, 64'h1, 5'h01, 1'b0, 1'b1, 1'b0);
      apply("R5 upper ignored slt", 64'h0000_0000_0000_0001, 64'h7FFF_0000_0000_0001, 5'h10, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_dword_mode;
      apply("R6 upper counts eq", 64'hFFFF_FFFF_0000_0001, 64'h1, 5'h04, 1'b1, 1'b1, 1'b0);
      apply("R6 upper slt", 64'hFFFF_FFFF_0000_0001, 64'h1, 5'h10, 1'b1, 1'b1, 1'b1);
      apply("R6 upper ugt", 64'hFFFF_FFFF_0000_0001, 64'h1, 5'h01, 1'b1, 1'b1, 1'b1);
      apply("R6 bit31 positive sgt", 64'h0000_0000_8000_0000, 64'h1, 5'h08, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_masks;
      apply("R8 zero mask", 64'h5, 64'h9, 5'h00, 1'b1, 1'b1, 1'b0);
      apply("R8 zero mask eq", 64'h9, 64'h9, 5'h00, 1'b0, 1'b1, 1'b0);
      apply("R8 full mask", 64'h5, 64'h9, 5'h1f, 1'b1, 1'b1, 1'b1);
      apply("R8 full mask eq", 64'h9, 64'h9, 5'h1f, 1'b0, 1'b1, 1'b1);
      // R7: several enables, only one of them true
      apply("R7 or one true", 64'h9, 64'h9, 5'h1d, 1'b1, 1'b1, 1'b1);
      apply("R7 or none true", 64'h9, 64'h9, 5'h1b, 1'b1, 1'b1, 1'b0);
      for (int m = 0; m < 32; m++) begin
         apply_model("R7 mask sweep", 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0010, m[4:0], 1'b1);
         apply_model("R7 mask sweep word", 64'h0000_0001_8000_0000, 64'h0000_0000_7FFF_FFFF, m[4:0], 1'b0);
      end
   endtask

   task automatic t_valid_gating;
      apply("R9 no valid", 64'h3, 64'h3, 5'h1f, 1'b1, 1'b0, 1'b0);
      apply("R9 valid", 64'h3, 64'h3, 5'h04, 1'b1, 1'b1, 1'b1);
      // R9/R10: request lasts a single cycle and the code returns to zero
      @(negedge clk);
      check("R10 idle after request", 1'b0);
   endtask

   initial begin
      t_reset();
      t_single_relations();
      t_word_mode();
      t_dword_mode();
      t_masks();
      t_valid_gating();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule